// File: doc/BRIEF.md
# Chained Fair-Share Service Request Arbiter

This block is the arbitration logic inside one serial controller. Several controllers share one open-drain, active-low service-request line and one active-low acknowledge line for each of three request types: receive, transmit and modem. Each device pulls its request line low while it has work of that type pending. It also watches the level of the shared line, so it can tell when another device still holds that line.

A grant signal runs down a chain of devices. The first device's grant input is tied active, and each device's pass output feeds the next device's grant input. When a shared acknowledge arrives, the device that holds grant and is requesting that type claims the cycle and keeps pass inactive. Any other device passes grant straight through without a register, so grant ripples down the chain inside the acknowledge cycle.

After a device has been serviced for a type, it holds off its request for that type until the shared line returns high. This fair-share holdoff gives waiting devices later in the chain their turn. Only hardware acknowledges are arbitrated. A per-device parallel-channel request path is outside this block.

Top module: `fs_chain_arbiter`

## Requirements
- R1: After reset, no type is held off or in service. Each request output then equals the inverse of its pending input, claim_o is zero, and pass_n_o equals grant_n_i.
- R2: For each type, req_n_o[t] is low exactly when req_pend_i[t] is high and type t is not held off. Types are independent. Bit 0 is receive, bit 1 is transmit and bit 2 is modem.
- R3: When ack_n_i[t] is low, grant_n_i is low, no type is in service and req_n_o[t] is low, claim_o[t] goes high in that same cycle and pass_n_o is high.
- R4: Whenever claim_o is all zero, pass_n_o equals grant_n_i in the same cycle, with no register between them.
- R5: A new claim never starts while grant_n_i is high.
- R6: Once claimed, claim_o[t] stays high for as long as ack_n_i[t] stays low, even after the request is released. It drops in the first cycle in which ack_n_i[t] is high.
- R7: From the cycle after a claim of type t starts, req_n_o[t] is high. It stays high while the shared line req_bus_n_i[t] is low.
- R8: At the first clock edge where req_bus_n_i[t] and ack_n_i[t] are both high, the holdoff of type t ends. From the next cycle, req_n_o[t] follows req_pend_i[t] again.
- R9: If acknowledges of several types are low and more than one type could start a claim, only the lowest-numbered type is claimed. claim_o is always one-hot or zero.
- R10: While one type is in service, no other type is claimed, even if its acknowledge is low and it is requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pend_i | input | N_TYPES | Pending work per type, active high |
| req_bus_n_i | input | N_TYPES | Observed level of the shared request lines |
| ack_n_i | input | N_TYPES | Shared acknowledges, active low |
| grant_n_i | input | 1 | Grant from the previous device, active low |
| req_n_o | output | N_TYPES | Open-drain request drive, low means asserted |
| claim_o | output | N_TYPES | This device answers the acknowledge of that type |
| pass_n_o | output | 1 | Grant to the next device, active low |

## Verification
Three outputs are combinational and are due in the same cycle as their stimulus: claim_o, pass_n_o, and req_n_o in response to pending work. Effects of the holdoff and in-service state appear one clock edge after the claim, or after the shared line and acknowledge return high. The bench drives each step just after a falling edge and samples 5 ns later, before the next rising edge. Each expected item therefore describes the state left by all earlier edges. Two devices are chained in the bench, and the shared lines are formed as the AND of their request outputs.

// File: rtl/fs_pkg.sv
package fs_pkg;
    parameter int unsigned FS_TYPES_DEF = 3;

    typedef struct packed {
        logic hold;     // fair-share holdoff active
        logic serving;  // acknowledge cycle owned by this device
    } fs_slot_t;
endpackage

// File: rtl/fs_type_slot.sv
module fs_type_slot
    import fs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic bus_n_i,
    input  logic ack_n_i,
    input  logic take_i,
    output logic req_n_o,
    output logic want_o,
    output logic busy_o
);
    fs_slot_t st_d, st_q;
    logic     active;

    always_comb begin
        active  = pend_i & ~st_q.hold;
        req_n_o = ~active;
        want_o  = ~ack_n_i & active & ~st_q.serving;
        busy_o  = ~ack_n_i & st_q.serving;

        st_d         = st_q;
        st_d.serving = ~ack_n_i & (st_q.serving | take_i);
        st_d.hold    = take_i | (st_q.hold & ~(bus_n_i & ack_n_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fs_chain_link.sv
module fs_chain_link #(
    parameter int unsigned N_TYPES = 3
) (
    input  logic               grant_n_i,
    input  logic [N_TYPES-1:0] want_i,
    input  logic [N_TYPES-1:0] busy_i,
    output logic [N_TYPES-1:0] claim_o,
    output logic               pass_n_o
);
    logic [N_TYPES-1:0] low_want;
    logic               found;

    always_comb begin
        low_want = '0;
        found    = 1'b0;
        for (int i = 0; i < N_TYPES; i++) begin
            if (want_i[i] && !found) begin
                low_want[i] = 1'b1;
                found       = 1'b1;
            end
        end
        if (|busy_i)        claim_o = busy_i;
        else if (grant_n_i) claim_o = '0;
        else                claim_o = low_want;
        pass_n_o = grant_n_i | (|claim_o);
    end
endmodule

// File: rtl/fs_chain_arbiter.sv
module fs_chain_arbiter #(
    parameter int unsigned N_TYPES = fs_pkg::FS_TYPES_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TYPES-1:0] req_pend_i,
    input  logic [N_TYPES-1:0] req_bus_n_i,
    input  logic [N_TYPES-1:0] ack_n_i,
    input  logic               grant_n_i,
    output logic [N_TYPES-1:0] req_n_o,
    output logic [N_TYPES-1:0] claim_o,
    output logic               pass_n_o
);
    logic [N_TYPES-1:0] want, busy;

    for (genvar t = 0; t < N_TYPES; t++) begin : g_slot
        fs_type_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .pend_i  (req_pend_i[t]),
            .bus_n_i (req_bus_n_i[t]),
            .ack_n_i (ack_n_i[t]),
            .take_i  (claim_o[t]),
            .req_n_o (req_n_o[t]),
            .want_o  (want[t]),
            .busy_o  (busy[t])
        );
    end

    fs_chain_link #(.N_TYPES(N_TYPES)) u_link (
        .grant_n_i (grant_n_i),
        .want_i    (want),
        .busy_i    (busy),
        .claim_o   (claim_o),
        .pass_n_o  (pass_n_o)
    );
endmodule

// File: rtl/fs_chain_arbiter_chk.sv
module fs_chain_arbiter_chk #(
    parameter int unsigned N_TYPES = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_TYPES-1:0] req_pend_i,
    input logic [N_TYPES-1:0] req_bus_n_i,
    input logic [N_TYPES-1:0] ack_n_i,
    input logic               grant_n_i,
    input logic [N_TYPES-1:0] req_n_o,
    input logic [N_TYPES-1:0] claim_o,
    input logic               pass_n_o
);
    AST_CLAIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_o)); // R9

    AST_CLAIM_BLOCKS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (|claim_o) |-> pass_n_o); // R3

    AST_PASS_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !(|claim_o) |-> (pass_n_o == grant_n_i)); // R4

    AST_NEW_CLAIM_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|claim_o) |-> !grant_n_i); // R5

    for (genvar t = 0; t < N_TYPES; t++) begin : g_type
        AST_CLAIM_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
            claim_o[t] |-> !ack_n_i[t]); // R6

        AST_RELEASE_AFTER_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_o[t] && !ack_n_i[t]) |=> req_n_o[t]); // R7

        AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            !req_n_o[t] |-> req_pend_i[t]); // R2
    end
endmodule

bind fs_chain_arbiter fs_chain_arbiter_chk #(.N_TYPES(N_TYPES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_pend_i  (req_pend_i),
    .req_bus_n_i (req_bus_n_i),
    .ack_n_i     (ack_n_i),
    .grant_n_i   (grant_n_i),
    .req_n_o     (req_n_o),
    .claim_o     (claim_o),
    .pass_n_o    (pass_n_o)
);

// File: tb/sim_fs_chain_arbiter.sv
module sim_fs_chain_arbiter;
    localparam int NT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] pend0 = '0, pend1 = '0, ack_n = '1;
    logic          g0_n = 1'b0;
    logic [NT-1:0] rq0, rq1, cl0, cl1, bus_n;
    logic          ps0, ps1;
    int            checks = 0, errors = 0;
    bit            done = 0;

    always #10 clk = ~clk;

    assign bus_n = rq0 & rq1;

    fs_chain_arbiter #(.N_TYPES(NT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_pend_i(pend0), .req_bus_n_i(bus_n),
        .ack_n_i(ack_n), .grant_n_i(g0_n), .req_n_o(rq0), .claim_o(cl0), .pass_n_o(ps0));

    fs_chain_arbiter #(.N_TYPES(NT)) u1 (
        .clk(clk), .rst_n(rst_n), .req_pend_i(pend1), .req_bus_n_i(bus_n),
        .ack_n_i(ack_n), .grant_n_i(ps0), .req_n_o(rq1), .claim_o(cl1), .pass_n_o(ps1));

    typedef struct {
        string         tag;
        logic [NT-1:0] r0, c0, r1, c1;
        logic          p0, p1;
    } exp_t;

    exp_t q[$];

    task automatic step(input logic [NT-1:0] p0i, p1i, ai, input logic gi,
                        input logic [NT-1:0] r0, c0, input logic pp0,
                        input logic [NT-1:0] r1, c1, input logic pp1,
                        input string tag);
        exp_t e;
        @(negedge clk);
        pend0 = p0i; pend1 = p1i; ack_n = ai; g0_n = gi;
        e.tag = tag; e.r0 = r0; e.c0 = c0; e.p0 = pp0;
        e.r1 = r1; e.c1 = c1; e.p1 = pp1;
        q.push_back(e);
    endtask

    task automatic cmp(input string tag, input string what, input logic [NT-1:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #5;
            while (q.size() > 0) begin
                e = q.pop_front();
                cmp(e.tag, "dev0 req_n", rq0, e.r0);
                cmp(e.tag, "dev0 claim", cl0, e.c0);
                cmp(e.tag, "dev0 pass_n", {2'b0, ps0}, {2'b0, e.p0});
                cmp(e.tag, "dev1 req_n", rq1, e.r1);
                cmp(e.tag, "dev1 claim", cl1, e.c1);
                cmp(e.tag, "dev1 pass_n", {2'b0, ps1}, {2'b0, e.p1});
            end
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        //    pend0   pend1   ack_n   g0   req0    clm0   ps0  req1    clm1   ps1
        step(3'b000, 3'b000, 3'b111, 0, 3'b111, 3'b000, 0, 3'b111, 3'b000, 0, "R1");
        step(3'b001, 3'b100, 3'b111, 0, 3'b110, 3'b000, 0, 3'b011, 3'b000, 0, "R2");
        step(3'b001, 3'b001, 3'b110, 0, 3'b110, 3'b001, 1, 3'b110, 3'b000, 1, "R3");
        step(3'b001, 3'b001, 3'b110, 0, 3'b111, 3'b001, 1, 3'b110, 3'b000, 1, "R6");
        step(3'b001, 3'b001, 3'b111, 0, 3'b111, 3'b000, 0, 3'b110, 3'b000, 0, "R7");
        step(3'b001, 3'b001, 3'b110, 0, 3'b111, 3'b000, 0, 3'b110, 3'b001, 1, "R4");
        step(3'b001, 3'b000, 3'b111, 0, 3'b111, 3'b000, 0, 3'b111, 3'b000, 0, "R7");
        step(3'b001, 3'b000, 3'b111, 0, 3'b110, 3'b000, 0, 3'b111, 3'b000, 0, "R8");
        step(3'b011, 3'b000, 3'b100, 0, 3'b100, 3'b001, 1, 3'b111, 3'b000, 1, "R9");
        step(3'b011, 3'b000, 3'b100, 0, 3'b101, 3'b001, 1, 3'b111, 3'b000, 1, "R10");
        step(3'b011, 3'b000, 3'b111, 0, 3'b101, 3'b000, 0, 3'b111, 3'b000, 0, "R6");
        step(3'b010, 3'b010, 3'b101, 1, 3'b101, 3'b000, 1, 3'b101, 3'b000, 1, "R5");
        step(3'b010, 3'b010, 3'b101, 0, 3'b101, 3'b010, 1, 3'b101, 3'b000, 1, "R3");
        step(3'b000, 3'b010, 3'b101, 0, 3'b111, 3'b010, 1, 3'b101, 3'b000, 1, "R6");
        step(3'b000, 3'b010, 3'b111, 0, 3'b111, 3'b000, 0, 3'b101, 3'b000, 0, "R4");
        step(3'b000, 3'b010, 3'b101, 1, 3'b111, 3'b000, 1, 3'b101, 3'b000, 1, "R5");
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #(20 * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule